// File: doc/BRIEF.md
# Single-Structure Vector Load/Store Decoder

This block decodes a 32-bit vector load/store instruction word of the single-structure family. It tells the issue logic whether the word is a legal one-lane access or a load-and-replicate, and whether it is a reserved encoding. For legal words it also reports the direction, the addressing mode, the register count, the register fields, the lane index, the element size and the byte count of an immediate post-increment. It touches neither memory nor register files.

The decode itself is combinational. A single registered output stage, with its own clock enable, captures the result whenever `in_vld` is high. `out_vld` follows `in_vld` one cycle later, and the outputs hold their value between captures. For reserved encodings the block raises `unalloc` and drives every other field inactive, so downstream logic never starts an access.

Top module: `ssd_top`

## Requirements
- R1: A word belongs to the family only when bit 31 is 0 and bits 29..25 equal 00110. Any other word gives `dec_ok`=0 and `unalloc`=0.
- R2: For a legal word, `nregs` = {bit13, bit21} + 1 (range 1..4). `vt` = bits 4..0, `rn` = bits 9..5, `rm` = bits 20..16, `is_load` = bit 22 and `is_post` = bit 23.
- R3: When bits 15..14 = 00, the access is a byte (`esize`=0) and `lane` = Q*8 + S*4 + size, where Q = bit 30, S = bit 12 and size = bits 11..10.
- R4: When bits 15..14 = 01 and size[0]=1, the word is reserved. Otherwise the access is a halfword (`esize`=1) and `lane` = Q*4 + S*2 + size[1].
- R5: When bits 15..14 = 10 and size[1]=1, the word is reserved. With size=00 the access is a word (`esize`=2) and `lane` = Q*2 + S. With size=01 and S=1 the word is reserved. With size=01 and S=0 the access is a doubleword (`esize`=3) and `lane` = Q.
- R6: When bits 15..14 = 11, a load with S=0 is a replicate (`op_repl`=1, `esize`=size, `lane`=0). A store, or a load with S=1, is reserved.
- R7: When post-indexed with `rm`=31, `use_imm_inc`=1 and `inc_bytes` = `nregs` * 2^`esize`. This holds for one-lane and replicate forms alike, with no doubling for Q. In every other case `use_imm_inc`=0 and `inc_bytes`=0.
- R8: A word that is not post-indexed (bit 23=0) and has bits 20..16 not equal to 0 is reserved.
- R9: A family word with bit 24=0 is reserved when bit 21=1. With bit 21=0 it gives `dec_ok`=0 and `unalloc`=0.
- R10: `dec_ok` and `unalloc` are never both 1. When `dec_ok`=0, every other output field except `unalloc` is 0.
- R11: The outputs are registered. A word presented with `in_vld`=1 appears one cycle later with `out_vld`=1. With `in_vld`=0 the outputs hold and `out_vld`=0 follows. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Capture enable for the instruction word |
| instr | input | 32 | Instruction word |
| out_vld | output | 1 | Registered copy of in_vld |
| dec_ok | output | 1 | Legal single-structure access |
| unalloc | output | 1 | Reserved encoding in the family |
| is_load | output | 1 | 1 = load, 0 = store |
| is_post | output | 1 | Post-indexed addressing |
| use_imm_inc | output | 1 | Immediate post-increment selected |
| op_repl | output | 1 | 1 = load-and-replicate, 0 = one lane |
| nregs | output | 3 | Register count 1..4 |
| vt | output | 5 | First vector register |
| rn | output | 5 | Base register |
| rm | output | 5 | Offset register field |
| lane | output | 4 | Lane index |
| esize | output | 2 | Element size code, bytes = 2^esize |
| inc_bytes | output | 6 | Immediate post-increment in bytes |

## Verification
Reserved-encoding detection and immediate post-increment computation can both act on the same word. Examples are a post-indexed word with `rm`=31 whose size bits are illegal for its opcode, and a post-indexed store in the replicate opcode. The sweep produces these pairs directly, because it crosses every opcode, size, S, Q, direction and R value with offset fields 0, 31 and a middle value under both addressing modes. The increment must then read 0, with `unalloc` high and all other fields cleared. A bench model built from the stated lane and byte-count formulas judges each of these vectors.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int INSTR_W     = 32;
  localparam int REG_IDX_W   = 5;
  localparam int MAX_REGS    = 4;
  localparam int MAX_ESZ_LOG = 3;
  localparam int NREG_W      = $clog2(MAX_REGS) + 1;
  localparam int LANE_W      = $clog2(16);
  localparam int ESZ_W       = $clog2(MAX_ESZ_LOG + 1);
  localparam int INC_W       = $clog2(MAX_REGS * (1 << MAX_ESZ_LOG)) + 1;
  localparam logic [4:0] FAMILY_CODE = 5'b00110;
  localparam logic [REG_IDX_W-1:0] IMM_SEL = '1;

  typedef struct packed {
    logic                 ok;
    logic                 unalloc;
    logic                 load;
    logic                 post;
    logic                 imm_inc;
    logic                 repl;
    logic [NREG_W-1:0]    nregs;
    logic [REG_IDX_W-1:0] vt;
    logic [REG_IDX_W-1:0] rn;
    logic [REG_IDX_W-1:0] rm;
    logic [LANE_W-1:0]    lane;
    logic [ESZ_W-1:0]     esize;
    logic [INC_W-1:0]     inc;
  } ssd_dec_t;
endpackage

// File: rtl/ssd_lane_unit.sv
module ssd_lane_unit
  import ssd_pkg::*;
(
  input  logic              q_bit,
  input  logic              s_bit,
  input  logic [1:0]        op_hi,
  input  logic [1:0]        size,
  output logic [LANE_W-1:0] lane,
  output logic [ESZ_W-1:0]  esize,
  output logic              repl_form,
  output logic              size_bad
);
  always_comb begin
    lane      = '0;
    esize     = '0;
    repl_form = 1'b0;
    size_bad  = 1'b0;
    unique case (op_hi)
      2'b00: begin
        lane  = {q_bit, s_bit, size};
        esize = ESZ_W'(0);
      end
      2'b01: begin
        size_bad = size[0];
        lane     = {1'b0, q_bit, s_bit, size[1]};
        esize    = ESZ_W'(1);
      end
      2'b10: begin
        size_bad = size[1] | (size[0] & s_bit);
        if (!size[0]) begin
          lane  = {2'b00, q_bit, s_bit};
          esize = ESZ_W'(2);
        end else begin
          lane  = {3'b000, q_bit};
          esize = ESZ_W'(3);
        end
      end
      default: begin
        repl_form = 1'b1;
        esize     = ESZ_W'(size);
      end
    endcase
  end
endmodule

// File: rtl/ssd_inc_unit.sv
module ssd_inc_unit
  import ssd_pkg::*;
(
  input  logic              sel_imm,
  input  logic [NREG_W-1:0] nregs,
  input  logic [ESZ_W-1:0]  esize,
  output logic [INC_W-1:0]  inc
);
  logic [INC_W-1:0] shifted [MAX_ESZ_LOG+1];

  for (genvar g = 0; g <= MAX_ESZ_LOG; g++) begin : g_shift
    assign shifted[g] = INC_W'(nregs) << g;
  end

  always_comb begin
    inc = '0;
    if (sel_imm) begin
      for (int k = 0; k <= MAX_ESZ_LOG; k++) begin
        if (esize == ESZ_W'(k)) inc = shifted[k];
      end
    end
  end
endmodule

// File: rtl/ssd_legal.sv
module ssd_legal
  import ssd_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  input  logic               size_bad,
  input  logic               repl_form,
  output logic               single_ok,
  output logic               reserved
);
  logic fam_hit, single, post, load, r_bit, s_bit, off_zero, bad;

  always_comb begin
    fam_hit  = (word[31] == 1'b0) && (word[29:25] == FAMILY_CODE);
    single   = word[24];
    post     = word[23];
    load     = word[22];
    r_bit    = word[21];
    s_bit    = word[12];
    off_zero = (word[20:16] == '0);
    bad      = size_bad
             | (repl_form & (~load | s_bit))
             | (~post & ~off_zero);
    single_ok = fam_hit & single & ~bad;
    reserved  = fam_hit & ((single & bad) | (~single & r_bit));
  end
endmodule

// File: rtl/ssd_top.sv
module ssd_top
  import ssd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [31:0]          instr,
  output logic                 out_vld,
  output logic                 dec_ok,
  output logic                 unalloc,
  output logic                 is_load,
  output logic                 is_post,
  output logic                 use_imm_inc,
  output logic                 op_repl,
  output logic [2:0]           nregs,
  output logic [4:0]           vt,
  output logic [4:0]           rn,
  output logic [4:0]           rm,
  output logic [3:0]           lane,
  output logic [1:0]           esize,
  output logic [5:0]           inc_bytes
);
  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  logic [LANE_W-1:0] l_lane;
  logic [ESZ_W-1:0]  l_esize;
  logic              l_repl, l_bad;
  logic              single_ok, reserved;
  logic [NREG_W-1:0] raw_nregs;
  logic              sel_imm;
  logic [INC_W-1:0]  raw_inc;

  ssd_lane_unit u_lane (
    .q_bit(instr[30]), .s_bit(instr[12]), .op_hi(instr[15:14]),
    .size(instr[11:10]), .lane(l_lane), .esize(l_esize),
    .repl_form(l_repl), .size_bad(l_bad)
  );

  ssd_legal u_legal (
    .word(instr), .size_bad(l_bad), .repl_form(l_repl),
    .single_ok(single_ok), .reserved(reserved)
  );

  assign raw_nregs = {1'b0, instr[13], instr[21]} + NREG_W'(1);
  assign sel_imm   = instr[23] && (instr[20:16] == IMM_SEL);

  ssd_inc_unit u_inc (
    .sel_imm(sel_imm), .nregs(raw_nregs), .esize(l_esize), .inc(raw_inc)
  );

  ssd_dec_t dec_c, dec_d, dec_q;
  logic     vld_d, vld_q;

  always_comb begin
    dec_c = '0;
    dec_c.unalloc = reserved;
    if (single_ok) begin
      dec_c.ok      = 1'b1;
      dec_c.load    = instr[22];
      dec_c.post    = instr[23];
      dec_c.imm_inc = sel_imm;
      dec_c.repl    = l_repl;
      dec_c.nregs   = raw_nregs;
      dec_c.vt      = instr[4:0];
      dec_c.rn      = instr[9:5];
      dec_c.rm      = instr[20:16];
      dec_c.lane    = l_repl ? '0 : l_lane;
      dec_c.esize   = l_esize;
      dec_c.inc     = raw_inc;
    end
  end

  always_comb begin
    vld_d = in_vld;
    dec_d = dec_q;
    if (in_vld) dec_d = dec_c;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      dec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      dec_q <= dec_d;
      vld_q <= vld_d;
    end
  end

  assign out_vld     = vld_q;
  assign dec_ok      = dec_q.ok;
  assign unalloc     = dec_q.unalloc;
  assign is_load     = dec_q.load;
  assign is_post     = dec_q.post;
  assign use_imm_inc = dec_q.imm_inc;
  assign op_repl     = dec_q.repl;
  assign nregs       = dec_q.nregs;
  assign vt          = dec_q.vt;
  assign rn          = dec_q.rn;
  assign rm          = dec_q.rm;
  assign lane        = dec_q.lane;
  assign esize       = dec_q.esize;
  assign inc_bytes   = dec_q.inc;

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(dec_ok && unalloc));
  a_r10_inactive: assert property (@(posedge clk) disable iff (!rst_n_int)
    !dec_ok |-> (nregs == 0 && lane == 0 && inc_bytes == 0 && !is_load
                 && !is_post && !op_repl && !use_imm_inc));
  a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n_int)
    dec_ok |-> (nregs >= 3'd1 && nregs <= 3'd4));
  a_r6_repl_lane: assert property (@(posedge clk) disable iff (!rst_n_int)
    (dec_ok && op_repl) |-> (lane == 0 && is_load));
  a_r7_inc_amount: assert property (@(posedge clk) disable iff (!rst_n_int)
    use_imm_inc |-> (inc_bytes == (6'(nregs) << esize) && rm == 5'd31 && is_post));
  a_r11_vld_follow: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(out_vld) |-> $past(in_vld));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n_int)
    !$past(in_vld) |-> ($stable(lane) && $stable(inc_bytes) && $stable(dec_ok)));
endmodule

// File: tb/sim_ssd_top.sv
module sim_ssd_top;
  import ssd_pkg::*;

  logic        clk, rst_n, in_vld;
  logic [31:0] instr;
  logic        out_vld, dec_ok, unalloc, is_load, is_post, use_imm_inc, op_repl;
  logic [2:0]  nregs;
  logic [4:0]  vt, rn, rm;
  logic [3:0]  lane;
  logic [1:0]  esize;
  logic [5:0]  inc_bytes;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  ssd_top u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .instr(instr),
    .out_vld(out_vld), .dec_ok(dec_ok), .unalloc(unalloc), .is_load(is_load),
    .is_post(is_post), .use_imm_inc(use_imm_inc), .op_repl(op_repl),
    .nregs(nregs), .vt(vt), .rn(rn), .rm(rm), .lane(lane), .esize(esize),
    .inc_bytes(inc_bytes)
  );

  function automatic ssd_dec_t got_now();
    ssd_dec_t g;
    g = '{ok:dec_ok, unalloc:unalloc, load:is_load, post:is_post,
          imm_inc:use_imm_inc, repl:op_repl, nregs:nregs, vt:vt, rn:rn,
          rm:rm, lane:lane, esize:esize, inc:inc_bytes};
    return g;
  endfunction

  function automatic ssd_dec_t model(logic [31:0] w);
    ssd_dec_t e;
    int q, s, sz, op, es, ln, nr;
    bit bad, rep;
    e = '0;
    if (w[31] != 1'b0 || w[29:25] != 5'b00110) return e;
    if (!w[24]) begin
      e.unalloc = w[21];
      return e;
    end
    q = int'(w[30]); s = int'(w[12]); sz = int'(w[11:10]); op = int'(w[15:14]);
    bad = 0; rep = 0; es = 0; ln = 0;
    case (op)
      0: begin es = 0; ln = q*8 + s*4 + sz; end
      1: begin if (sz % 2 == 1) bad = 1; es = 1; ln = q*4 + s*2 + sz/2; end
      2: begin
        if (sz >= 2) bad = 1;
        if (sz % 2 == 0) begin es = 2; ln = q*2 + s; end
        else begin if (s == 1) bad = 1; es = 3; ln = q; end
      end
      default: begin
        if (!w[22] || s == 1) bad = 1;
        rep = 1; es = sz; ln = 0;
      end
    endcase
    if (!w[23] && w[20:16] != 0) bad = 1;
    if (bad) begin
      e.unalloc = 1'b1;
      return e;
    end
    nr = int'(w[13])*2 + int'(w[21]) + 1;
    e.ok = 1'b1; e.load = w[22]; e.post = w[23]; e.repl = rep;
    e.nregs = 3'(nr); e.vt = w[4:0]; e.rn = w[9:5]; e.rm = w[20:16];
    e.lane = 4'(ln); e.esize = 2'(es);
    e.imm_inc = w[23] && (w[20:16] == 5'd31);
    e.inc = e.imm_inc ? 6'(nr * (1 << es)) : 6'd0;
    return e;
  endfunction

  function automatic string tag_of(logic [31:0] w);
    if (w[31] != 1'b0 || w[29:25] != 5'b00110) return "R1";
    if (!w[24]) return "R9";
    if (!w[23] && w[20:16] != 0) return "R8";
    case (w[15:14])
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, ssd_dec_t got, ssd_dec_t exp, logic [31:0] w);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s instr=%h actual=%h expected=%h", req, w, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] w);
    ssd_dec_t g, e, z;
    @(negedge clk);
    instr = w; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    g = got_now(); e = model(w); z = '0;
    check(tag_of(w), g, e, w);
    n_vec++;
    if (out_vld !== 1'b1) begin
      n_bad++; $display("FAIL R11 out_vld actual=%b expected=1", out_vld);
    end
    if (e.ok) begin
      z = e;
      z.nregs = 3'(int'(w[13])*2 + int'(w[21]) + 1);
      check("R2", g, z, w);
    end
    if (w[23] && w[20:16] == 5'd31 && e.ok) check("R7", g, e, w);
    if (!e.ok) begin
      z = '0; z.unalloc = e.unalloc;
      check("R10", g, z, w);
    end
  endtask

  initial begin
    ssd_dec_t hold, z;
    logic [31:0] w;
    rst_n = 1'b0; in_vld = 1'b0; instr = '0;
    repeat (3) @(negedge clk);
    z = '0;
    check("R11", got_now(), z, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < 2048 * 3; v++) begin
      int b, k;
      logic [4:0] rmv;
      b = v / 3; k = v % 3;
      rmv = (k == 0) ? 5'd0 : (k == 1) ? 5'd31 : 5'((v % 29) + 1);
      w = {1'b0, 1'(b >> 10), 5'b00110, 1'(b >> 9), 1'(b >> 8), 1'(b >> 7),
           1'(b >> 6), rmv, 3'(b >> 3), 1'(b >> 2), 2'(b), 5'(b >> 4),
           5'(b) ^ 5'h15};
      apply(w);
    end

    for (int v = 0; v < 64; v++) begin
      w = {1'b0, 1'b1, 5'b00110, 1'b1, 1'b1, 1'b1, 1'b0, 5'd31, 3'b000,
           1'b0, 2'(v), 5'd3, 5'(v)};
      if (v % 2 == 0) w[31] = 1'b1;
      else w[29:25] = 5'(v);
      apply(w);
    end

    apply(32'h4DDFE000 | 32'h0000_0C00);
    hold = got_now();
    @(negedge clk);
    instr = 32'h0D40_0000; in_vld = 1'b0;
    @(negedge clk);
    check("R11", got_now(), hold, instr);
    n_vec++;
    if (out_vld !== 1'b0) begin
      n_bad++; $display("FAIL R11 out_vld actual=%b expected=0", out_vld);
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule